// File: doc/BRIEF.md
# Sequential Integer Square Rooter

This block computes the integer square root of an unsigned radicand of 2K bits, one root bit per clock cycle. A start pulse captures the radicand and a mode select. The block then walks the radicand two bits at a time from the most significant end. Each step shifts the partial remainder left by two places, brings in the next bit pair, and then runs a single add/subtract against the partial root extended by two low bits. The outcome gives the K-bit root and a remainder of K+1 bits, where the remainder equals the radicand minus the square of the root.

Two algorithms share the same adder. In restoring mode, a trial difference that is negative is discarded and the shifted remainder is kept. In nonrestoring mode, the signed remainder is always kept, and its sign chooses whether the next step subtracts or adds. The root bits are collected directly in plain binary as each step finishes. One extra cycle then repairs a negative final remainder by adding back twice the root plus one. Fixed-point significands use the same unit: a radicand with 2F fraction bits gives a root with F fraction bits.

Top module: `isqrt_seq`

## Requirements
- R1: While reset is held and after it is released, busy and done are 0 and root and remainder read 0 until the first accepted start.
- R2: With nonRestMode at 0 when start is taken, the root equals floor(sqrt(radicand)) and the remainder equals radicand minus root squared, for every 2K-bit radicand.
- R3: With nonRestMode at 1 when start is taken, the root and remainder are identical to those of R2, including cases where the last step leaves a negative remainder that needs repair.
- R4: When done is high, the remainder is non-negative and no greater than twice the root.
- R5: A start is sampled at a rising edge when busy is 0. The done signal is high in the cycle that follows the Kth later rising edge in restoring mode, and the (K+1)th later rising edge in nonrestoring mode.
- R6: Busy is 1 from the edge that accepts start until done rises, and is 0 in the cycle where done is high. Done is high for exactly one cycle.
- R7: A start pulse while busy is 1 has no effect: the running operation keeps its radicand, its latency and its result, and no second operation follows.
- R8: Once done has been shown, root and remainder hold their values until the next start is accepted.
- R9: Changing nonRestMode or radicand during an operation has no effect on it. Only the values present at the accepting edge count.
- R10: The corner values give these results. 118 gives root 10, remainder 18. 7552 (118/64 with twelve fraction bits) gives root 86, remainder 156. 0 gives 0, 0. 65535 gives 255, 510. 65025 gives 255, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when the unit is idle |
| nonRestMode | input | 1 | 1 selects nonrestoring steps, 0 selects restoring steps; sampled with start |
| radicand | input | 2K | Unsigned operand, sampled with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when root and remainder are final |
| root | output | K | Integer square root |
| remainder | output | K+1 | Radicand minus root squared |

## Verification
On every clock, the assertions check several properties. Done is a single-cycle pulse that follows the last step after the fixed number of cycles. In restoring mode, the held remainder never goes negative, and a repair cycle always leaves it non-negative. At done, the remainder is bounded by twice the root, and while idle the outputs hold. Only the bench scenarios can show the actual root and remainder values against an independent square computation in both modes. They also show that a start, mode flip or radicand change during a run leaves the result untouched. The directed corner values and the fractional scaling case come from the bench as well.

// File: rtl/isqrt_pkg.sv
`timescale 1ns/1ps
package isqrt_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operand, clear root and remainder
    logic step;   // one root-bit iteration
    logic fix;    // nonrestoring remainder repair
  } dpCtrl_t;
endpackage

// File: rtl/isqrt_ctrl.sv
`timescale 1ns/1ps
module isqrt_ctrl
  import isqrt_pkg::*;
#(
  parameter int K = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    modeIn,
  output dpCtrl_t ctl,
  output logic    nonRest,
  output logic    busy,
  output logic    done
);
  localparam int CW = (K > 1) ? $clog2(K) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          modeQ;
  logic          doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      modeQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= CW'(K - 1);
          modeQ <= modeIn;
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == '0) begin
            if (modeQ) state <= ST_FIX;
            else begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end
          end
        end
        ST_FIX: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load = (state == ST_IDLE) && start;
    ctl.step = (state == ST_RUN);
    ctl.fix  = (state == ST_FIX);
  end

  assign nonRest = modeQ;
  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> (busy && !done)); // R6
  AST_REST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && cnt == '0 && !modeQ) |=> done); // R5
  AST_NR_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && cnt == '0 && modeQ) |=> (!done ##1 done)); // R5
endmodule

// File: rtl/isqrt_dpath.sv
`timescale 1ns/1ps
module isqrt_dpath
  import isqrt_pkg::*;
#(
  parameter int K = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtrl_t        ctl,
  input  logic           nonRest,
  input  logic [2*K-1:0] radIn,
  output logic [K-1:0]   root,
  output logic [K:0]     rem
);
  localparam int W  = K + 2;   // adder and partial-remainder width
  localparam int RW = 2 * K;

  logic [RW-1:0] radReg;
  logic [W-1:0]  remReg;
  logic [K-1:0]  rootReg;

  logic [W-1:0]  shifted;
  logic [W-1:0]  opA;
  logic [W-1:0]  trialT;
  logic [W-1:0]  opB;
  logic          subOp;
  logic [W-1:0]  sum;
  logic          newBit;

  assign shifted = {remReg[W-3:0], radReg[RW-1 -: 2]};

  always_comb begin
    if (ctl.fix) begin
      opA    = remReg;
      trialT = {1'b0, rootReg, 1'b1};
      subOp  = 1'b0;
    end else begin
      opA    = shifted;
      subOp  = !nonRest || !remReg[W-1];
      trialT = subOp ? {rootReg, 2'b01} : {rootReg, 2'b11};
    end
    opB = subOp ? ~trialT : trialT;
  end

  // the single shared adder; carry-in is the complement control
  assign sum    = opA + opB + W'(subOp);
  assign newBit = !sum[W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      radReg  <= '0;
      remReg  <= '0;
      rootReg <= '0;
    end else if (ctl.load) begin
      radReg  <= radIn;
      remReg  <= '0;
      rootReg <= '0;
    end else if (ctl.step) begin
      radReg  <= radReg << 2;
      rootReg <= {rootReg[K-2:0], newBit};
      remReg  <= (nonRest || newBit) ? sum : shifted;
    end else if (ctl.fix) begin
      if (remReg[W-1]) remReg <= sum;
    end
  end

  assign root = rootReg;
  assign rem  = remReg[K:0];

  AST_REST_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !nonRest) |=> !remReg[W-1]); // R2
  AST_FIX_NONNEG: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fix |=> !remReg[W-1]); // R3
endmodule

// File: rtl/isqrt_seq.sv
`timescale 1ns/1ps
module isqrt_seq
  import isqrt_pkg::*;
#(
  parameter int K = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           nonRestMode,
  input  logic [2*K-1:0] radicand,
  output logic           busy,
  output logic           done,
  output logic [K-1:0]   root,
  output logic [K:0]     remainder
);
  dpCtrl_t ctl;
  logic    nonRest;

  isqrt_ctrl #(.K(K)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(nonRestMode),
    .ctl(ctl), .nonRest(nonRest), .busy(busy), .done(done)
  );

  isqrt_dpath #(.K(K)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .nonRest(nonRest),
    .radIn(radicand), .root(root), .rem(remainder)
  );

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (remainder <= {root, 1'b0})); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(root) && $stable(remainder))); // R8
endmodule

// File: tb/isqrt_seq_tb.sv
`timescale 1ns/1ps
module isqrt_seq_tb_top;
  localparam int K = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic           nonRestMode = 1'b0;
  logic [2*K-1:0] radicand = '0;
  logic           busy, done;
  logic [K-1:0]   root;
  logic [K:0]     remainder;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  isqrt_seq #(.K(K)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .nonRestMode(nonRestMode),
    .radicand(radicand), .busy(busy), .done(done), .root(root),
    .remainder(remainder)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // greedy bit-by-bit search using plain squaring
  function automatic longint refRoot(input longint z);
    longint r = 0;
    for (int b = K - 1; b >= 0; b--) begin
      longint c = r | (longint'(1) << b);
      if (c * c <= z) r = c;
    end
    return r;
  endfunction

  task automatic runOp(input logic [2*K-1:0] z, input bit m, input bit interfere);
    longint er, es;
    int cyc, expLat;
    logic [K-1:0] rHold;
    logic [K:0]   sHold;
    string tagV;
    er = refRoot(longint'(z));
    es = longint'(z) - er * er;
    expLat = m ? K + 1 : K;
    tagV = m ? "R3" : "R2";
    @(negedge clk);
    radicand = z; nonRestMode = m; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R6 busy after start", longint'(busy), 1);
    cyc = 0;
    while (!done && cyc < 40) begin
      if (interfere && cyc == 2) begin
        start = 1'b1; radicand = ~z; nonRestMode = !m;   // R7 R9
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc == expLat, "R5 latency", longint'(cyc), longint'(expLat));
    chk(busy === 1'b0, "R6 busy low at done", longint'(busy), 0);
    chk(longint'(root) == er, interfere ? "R7 root" : {tagV, " root"}, longint'(root), er);
    chk(longint'(remainder) == es, interfere ? "R9 remainder" : {tagV, " remainder"},
        longint'(remainder), es);
    chk(longint'(remainder) <= 2 * longint'(root), "R4 bound",
        longint'(remainder), 2 * longint'(root));
    rHold = root; sHold = remainder;
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R6 done single pulse", longint'(done), 0);
    chk(busy === 1'b0, interfere ? "R7 no second run" : "R6 idle", longint'(busy), 0);
    chk(root === rHold && remainder === sHold, "R8 hold",
        longint'(remainder), longint'(sHold));
  endtask

  initial begin
    #1ms;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset flags", longint'({busy, done}), 0);
    chk(root === '0 && remainder === '0, "R1 reset outputs", longint'(remainder), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(root === '0 && remainder === '0 && !busy, "R1 after release", longint'(root), 0);

    // R10 directed corner values, both modes
    for (int m = 0; m < 2; m++) begin
      runOp(16'd118, m[0], 1'b0);
      chk(root == 10 && remainder == 18, "R10 118", longint'(root), 10);
      runOp(16'd7552, m[0], 1'b0);
      chk(root == 86 && remainder == 156, "R10 fractional", longint'(remainder), 156);
      runOp(16'd0, m[0], 1'b0);
      chk(root == 0 && remainder == 0, "R10 zero", longint'(root), 0);
      runOp(16'hFFFF, m[0], 1'b0);
      chk(root == 255 && remainder == 510, "R10 max", longint'(remainder), 510);
      runOp(16'd65025, m[0], 1'b0);
      chk(root == 255 && remainder == 0, "R10 square", longint'(remainder), 0);
      runOp(16'd2, m[0], 1'b0);
      runOp(16'd1, m[0], 1'b0);
    end

    // R7 R9 start and mode change during a run
    runOp(16'd118, 1'b0, 1'b1);
    runOp(16'd118, 1'b1, 1'b1);
    runOp(16'd40000, 1'b0, 1'b1);
    runOp(16'd40000, 1'b1, 1'b1);

    // R2 R3 constrained random
    for (int i = 0; i < 300; i++) begin
      logic [2*K-1:0] z;
      z = 16'($urandom());
      if (i % 4 == 0) z = z >> ($urandom() % 14);
      runOp(z, 1'($urandom()), (i % 17) == 5);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule